// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block produces the source operand of a two-operand arithmetic instruction. It supports ten addressing modes. From a mode code, one or two register specifiers and a constant field, it works out the effective data address. It then reads the data memory once, or twice in a chain, and returns the operand together with a one-cycle completion strobe. The two auto-modifying modes also write the adjusted base register back through a dedicated register-file write port.

The register-file read ports are combinational and are addressed straight from the specifier inputs in the cycle that `start_i` is accepted. The data memory answers one cycle after a read request. A single controller sequences every mode and reports each instruction as finished on `done_o`.

`ea_o` holds the most recent address that was sent to memory. The access size `STEP` is a parameter. When it is a power of two, the scaled index is formed by a shift.

Top module: `operand_agen`

## Requirements
- R1: Mode codes: 0 register, 1 immediate, 2 displacement, 3 register-indirect, 4 indexed, 5 direct, 6 memory-indirect, 7 post-increment, 8 pre-decrement, 9 scaled. Mode 0 returns the register named by `reg_a_i` and mode 1 returns `imm_i`. Neither issues a memory read, and `done_o` rises one cycle after the start cycle.
- R2: Displacement mode reads memory at `imm_i` plus the base register. Register-indirect mode reads at the base register.
- R3: Indexed mode reads at the sum of the registers named by `reg_a_i` and `reg_b_i`. Direct mode reads at `imm_i`.
- R4: Memory-indirect mode reads at the base register and then reads at the returned word. It makes exactly two reads, returns the second word, sets `ea_o` to the second address, and raises `done_o` three cycles after start.
- R5: Post-increment mode reads at the base value and writes base+STEP into register `reg_a_i`.
- R6: Pre-decrement mode reads at base−STEP and writes that same value into register `reg_a_i`.
- R7: The base write happens exactly once per instruction, only in modes 7 and 8, and in the `done_o` cycle. An instruction started after it sees the updated register.
- R8: All single-read modes issue one read and raise `done_o` two cycles after start.
- R9: `done_o` lasts one cycle. `ea_o` keeps the last memory address and is not changed by modes 0, 1 or illegal codes. After reset, `done_o`, `busy_o` and `ea_o` are all 0.
- R10: A start that arrives while `busy_o` is high has no effect: no extra result, no read and no write.
- R11: Codes 10–15 raise `illegal_o` with `done_o` one cycle after start and return operand 0. They make no read and no register write.
- R12: Scaled mode reads at `imm_i` + base + (index register × STEP).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an instruction (taken when idle) |
| mode_i | input | 4 | Addressing mode code |
| reg_a_i | input | RA | Base/source register specifier |
| reg_b_i | input | RA | Index register specifier |
| imm_i | input | W | Displacement, immediate or direct address |
| rf_raddr_a_o | output | RA | Register read port A address |
| rf_rdata_a_i | input | W | Register read port A data |
| rf_raddr_b_o | output | RA | Register read port B address |
| rf_rdata_b_i | input | W | Register read port B data |
| rf_we_o | output | 1 | Register write enable (base update) |
| rf_waddr_o | output | RA | Register write address |
| rf_wdata_o | output | W | Register write data |
| mem_re_o | output | 1 | Data memory read request |
| mem_addr_o | output | W | Data memory read address |
| mem_rdata_i | input | W | Read data, one cycle after request |
| busy_o | output | 1 | Instruction in flight |
| done_o | output | 1 | One-cycle completion strobe |
| operand_o | output | W | Fetched operand, valid with `done_o` |
| ea_o | output | W | Last effective address |
| illegal_o | output | 1 | Illegal mode, valid with `done_o` |

## Verification
The bench concentrates on the chained memory-indirect read. A design that reused the base register as the second address, or that latched the first word, would return the wrong operand or a wrong `ea_o`, and its read count would differ from two.

Post-increment is run twice on the same register. The second run exposes a write-back that comes late, is missing, or happens more than once, because its address would then be off by STEP. Pre-decrement is checked to read at the decremented address rather than the original one.

Starts are held high, with a pre-decrement instruction on the inputs, throughout a busy window. If the block accepted them, it would produce an extra `done_o` or corrupt a register. Illegal codes are checked for a zero operand and for the absence of any access.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    AM_REG  = 4'd0,
    AM_IMM  = 4'd1,
    AM_DISP = 4'd2,
    AM_RIND = 4'd3,
    AM_IDX  = 4'd4,
    AM_DIR  = 4'd5,
    AM_MIND = 4'd6,
    AM_AINC = 4'd7,
    AM_ADEC = 4'd8,
    AM_SCL  = 4'd9
  } am_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WAIT1 = 2'd1,
    S_WAIT2 = 2'd2,
    S_FIN   = 2'd3
  } st_e;

  typedef struct packed {
    logic illegal;
    logic mem;
    logic chain;
    logic wb;
  } plan_t;
endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic [3:0]   mode_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] idx_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] direct_o,
  output logic [W-1:0] wb_val_o,
  output plan_t        plan_o
);
  localparam logic [W-1:0] STEP_W = W'(STEP);
  localparam int SH = $clog2(STEP);
  localparam bit POW2 = (STEP > 0) && ((STEP & (STEP - 1)) == 0);

  logic [W-1:0] scaled;

  generate
    if (POW2) begin : g_shift
      assign scaled = idx_i << SH;
    end else begin : g_mult
      assign scaled = idx_i * STEP_W;
    end
  endgenerate

  always_comb begin
    addr_o   = base_i;
    direct_o = '0;
    wb_val_o = '0;
    plan_o   = '{illegal: 1'b0, mem: 1'b1, chain: 1'b0, wb: 1'b0};
    case (mode_i)
      AM_REG: begin
        plan_o.mem = 1'b0;
        direct_o   = base_i;
      end
      AM_IMM: begin
        plan_o.mem = 1'b0;
        direct_o   = imm_i;
      end
      AM_DISP: addr_o = imm_i + base_i;
      AM_RIND: addr_o = base_i;
      AM_IDX:  addr_o = base_i + idx_i;
      AM_DIR:  addr_o = imm_i;
      AM_MIND: begin
        addr_o       = base_i;
        plan_o.chain = 1'b1;
      end
      AM_AINC: begin
        addr_o    = base_i;
        wb_val_o  = base_i + STEP_W;
        plan_o.wb = 1'b1;
      end
      AM_ADEC: begin
        wb_val_o  = base_i - STEP_W;
        addr_o    = base_i - STEP_W;
        plan_o.wb = 1'b1;
      end
      AM_SCL:  addr_o = imm_i + base_i + scaled;
      default: begin
        plan_o.mem     = 1'b0;
        plan_o.illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int W  = 32,
  parameter int RA = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  plan_t         plan_i,
  input  logic [W-1:0]  addr_i,
  input  logic [W-1:0]  direct_i,
  input  logic [W-1:0]  wb_val_i,
  input  logic [RA-1:0] reg_a_i,
  input  logic [W-1:0]  mem_rdata_i,
  output logic          mem_re_o,
  output logic [W-1:0]  mem_addr_o,
  output logic          rf_we_o,
  output logic [RA-1:0] rf_waddr_o,
  output logic [W-1:0]  rf_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  operand_o,
  output logic [W-1:0]  ea_o,
  output logic          illegal_o
);
  st_e           state_q, state_d;
  logic          accept;
  logic          chain_q, wb_q, ill_q;
  logic [RA-1:0] wreg_q;
  logic [W-1:0]  wval_q, op_q, op_d, ea_q;
  logic          op_en;

  assign accept = start_i && (state_q == S_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (accept) state_d = plan_i.mem ? S_WAIT1 : S_FIN;
      S_WAIT1: state_d = chain_q ? S_WAIT2 : S_FIN;
      S_WAIT2: state_d = S_FIN;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    mem_re_o   = (accept && plan_i.mem) || (state_q == S_WAIT1 && chain_q);
    mem_addr_o = (state_q == S_WAIT1) ? mem_rdata_i : addr_i;
    op_en      = 1'b0;
    op_d       = mem_rdata_i;
    if (accept && !plan_i.mem) begin
      op_en = 1'b1;
      op_d  = plan_i.illegal ? '0 : direct_i;
    end else if ((state_q == S_WAIT1 && !chain_q) || state_q == S_WAIT2) begin
      op_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      chain_q <= 1'b0;
      wb_q    <= 1'b0;
      ill_q   <= 1'b0;
      wreg_q  <= '0;
      wval_q  <= '0;
      op_q    <= '0;
      ea_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        chain_q <= plan_i.chain;
        wb_q    <= plan_i.wb;
        ill_q   <= plan_i.illegal;
        wreg_q  <= reg_a_i;
        wval_q  <= wb_val_i;
      end
      if (op_en) op_q <= op_d;
      if (mem_re_o) ea_q <= mem_addr_o;
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_FIN);
  assign rf_we_o    = done_o && wb_q;
  assign rf_waddr_o = wreg_q;
  assign rf_wdata_o = wval_q;
  assign operand_o  = op_q;
  assign ea_o       = ea_q;
  assign illegal_o  = done_o && ill_q;

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  a_r7_wb_once: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |=> !rf_we_o);
  a_r11_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (operand_o == '0) && !rf_we_o);
  a_r8_read_makes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re_o && !busy_o) |=> busy_o);
  a_r10_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_re_o);
endmodule

// File: rtl/operand_agen.sv
module operand_agen
  import ea_pkg::*;
#(
  parameter int W    = 32,
  parameter int RA   = 5,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [RA-1:0] reg_a_i,
  input  logic [RA-1:0] reg_b_i,
  input  logic [W-1:0]  imm_i,
  output logic [RA-1:0] rf_raddr_a_o,
  input  logic [W-1:0]  rf_rdata_a_i,
  output logic [RA-1:0] rf_raddr_b_o,
  input  logic [W-1:0]  rf_rdata_b_i,
  output logic          rf_we_o,
  output logic [RA-1:0] rf_waddr_o,
  output logic [W-1:0]  rf_wdata_o,
  output logic          mem_re_o,
  output logic [W-1:0]  mem_addr_o,
  input  logic [W-1:0]  mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  operand_o,
  output logic [W-1:0]  ea_o,
  output logic          illegal_o
);
  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  logic [W-1:0] addr, direct, wb_val;
  plan_t        plan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign rf_raddr_a_o = reg_a_i;
  assign rf_raddr_b_o = reg_b_i;

  ea_addr_calc #(.W(W), .STEP(STEP)) u_calc (
    .mode_i   (mode_i),
    .base_i   (rf_rdata_a_i),
    .idx_i    (rf_rdata_b_i),
    .imm_i    (imm_i),
    .addr_o   (addr),
    .direct_o (direct),
    .wb_val_o (wb_val),
    .plan_o   (plan)
  );

  ea_seq #(.W(W), .RA(RA)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .plan_i      (plan),
    .addr_i      (addr),
    .direct_i    (direct),
    .wb_val_i    (wb_val),
    .reg_a_i     (reg_a_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .rf_we_o     (rf_we_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_wdata_o  (rf_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .operand_o   (operand_o),
    .ea_o        (ea_o),
    .illegal_o   (illegal_o)
  );
endmodule

// File: tb/operand_agen_test.sv
module operand_agen_test;
  import ea_pkg::*;
  localparam int W = 32, RA = 5, STEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [3:0] mode_i = '0;
  logic [RA-1:0] reg_a_i = '0, reg_b_i = '0;
  logic [W-1:0] imm_i = '0;
  logic [RA-1:0] rf_raddr_a_o, rf_raddr_b_o, rf_waddr_o;
  logic [W-1:0] rf_rdata_a_i, rf_rdata_b_i, rf_wdata_o, mem_addr_o, operand_o, ea_o;
  logic [W-1:0] mem_rdata_i = '0;
  logic rf_we_o, mem_re_o, busy_o, done_o, illegal_o;

  logic [W-1:0] rf [32];
  int checks = 0, errors = 0, wb_cnt = 0, rd_cnt = 0;
  bit live = 1'b0, finished = 1'b0;

  typedef struct { logic [W-1:0] op; logic [W-1:0] ea; logic ill; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  operand_agen #(.W(W), .RA(RA), .STEP(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .reg_a_i(reg_a_i), .reg_b_i(reg_b_i), .imm_i(imm_i),
    .rf_raddr_a_o(rf_raddr_a_o), .rf_rdata_a_i(rf_rdata_a_i),
    .rf_raddr_b_o(rf_raddr_b_o), .rf_rdata_b_i(rf_rdata_b_i),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .operand_o(operand_o), .ea_o(ea_o),
    .illegal_o(illegal_o)
  );

  function automatic logic [W-1:0] memval(input logic [W-1:0] a);
    case (a)
      100: return 400;
      200: return 500;
      300: return 600;
      400: return 700;
      500: return 800;
      default: return a * 3 + 7;
    endcase
  endfunction

  assign rf_rdata_a_i = rf[rf_raddr_a_o];
  assign rf_rdata_b_i = rf[rf_raddr_b_o];

  always @(posedge clk) begin
    if (rf_we_o) begin
      rf[rf_waddr_o] <= rf_wdata_o;
      wb_cnt = wb_cnt + 1;
    end
    if (mem_re_o) begin
      mem_rdata_i <= memval(mem_addr_o);
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops scoreboard entries as results appear
  always @(negedge clk) begin
    if (live && done_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(operand_o == e.op, {e.tag, " operand"}, operand_o, e.op);
        chk(ea_o == e.ea, {e.tag, " ea"}, ea_o, e.ea);
        chk(illegal_o == e.ill, {e.tag, " illegal"}, illegal_o, e.ill);
      end
    end
  end

  task automatic run(input logic [3:0] m, input int a, input int b, input logic [W-1:0] imm,
                     input logic [W-1:0] eop, input logic [W-1:0] eea, input bit eill,
                     input int elat, input int erd, input int ewb, input string tag, input bit junk);
    int cyc;
    exp_t e;
    @(negedge clk);
    wb_cnt = 0; rd_cnt = 0;
    mode_i = m; reg_a_i = RA'(a); reg_b_i = RA'(b); imm_i = imm; start_i = 1'b1;
    e.op = eop; e.ea = eea; e.ill = eill; e.tag = tag;
    sb.push_back(e);
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (done_o || cyc > 20) break;
      if (junk) begin
        start_i = 1'b1; mode_i = AM_ADEC; reg_a_i = 5'd1; imm_i = 32'h55;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    chk(cyc == elat, {tag, " latency"}, cyc, elat);
    @(posedge clk); #1;
    chk(rd_cnt == erd, {tag, " reads"}, rd_cnt, erd);
    chk(wb_cnt == ewb, {tag, " writes"}, wb_cnt, ewb);
  endtask

  initial begin
    #200000;
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = i * 16;
    rf[1] = 100; rf[2] = 30; rf[3] = 70; rf[4] = 200;
    rf[5] = 304; rf[6] = 40; rf[7] = 5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(done_o == 0, "R9 reset done", done_o, 0);
    chk(busy_o == 0, "R9 reset busy", busy_o, 0);
    chk(ea_o == 0, "R9 reset ea", ea_o, 0);
    chk(mem_re_o == 0 && rf_we_o == 0, "R9 reset access", mem_re_o, 0);
    live = 1'b1;

    run(AM_DISP, 1, 0, 200, 600, 300, 0, 2, 1, 0, "R2 displacement", 0);
    run(AM_RIND, 1, 0, 0, 400, 100, 0, 2, 1, 0, "R2 reg-indirect", 0);
    run(AM_MIND, 1, 0, 0, 700, 400, 0, 3, 2, 0, "R4 mem-indirect busy-start R10", 1);
    chk(rf[1] == 100, "R10 ignored start left r1", rf[1], 100);
    run(AM_REG, 3, 0, 0, 70, 400, 0, 1, 0, 0, "R1 register", 0);
    run(AM_IMM, 0, 0, 32'hDEADBEEF, 32'hDEADBEEF, 400, 0, 1, 0, 0, "R1 immediate", 0);
    run(AM_IDX, 2, 3, 0, 400, 100, 0, 2, 1, 0, "R3 indexed", 0);
    run(AM_DIR, 0, 0, 500, 800, 500, 0, 2, 1, 0, "R3 direct R8", 0);
    run(AM_AINC, 4, 0, 0, 500, 200, 0, 2, 1, 1, "R5 post-increment", 0);
    chk(rf[4] == 204, "R5 base updated", rf[4], 204);
    run(AM_AINC, 4, 0, 0, memval(204), 204, 0, 2, 1, 1, "R7 sees update", 0);
    chk(rf[4] == 208, "R7 second update", rf[4], 208);
    run(AM_ADEC, 5, 0, 0, 600, 300, 0, 2, 1, 1, "R6 pre-decrement", 0);
    chk(rf[5] == 300, "R6 base updated", rf[5], 300);
    run(AM_SCL, 6, 7, 100, memval(160), 160, 0, 2, 1, 0, "R12 scaled", 0);
    run(4'd12, 1, 2, 77, 0, 160, 1, 1, 0, 0, "R11 illegal 12", 0);
    run(4'd15, 1, 2, 77, 0, 160, 1, 1, 0, 0, "R11 illegal 15", 1);
    run(AM_MIND, 4, 0, 0, memval(memval(208)), memval(208), 0, 3, 2, 0, "R4 chained", 0);
    run(AM_REG, 1, 0, 0, 100, memval(208), 0, 1, 0, 0, "R9 ea held", 0);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R10 leftover results", sb.size(), 0);
    report();
  end
endmodule